// File: doc/BRIEF.md
# Synchronous Serial Codec Port

This block is the word-serial link between a codec's internal datapath and a host signal processor. It derives a serial clock from the master clock, shifts 16-bit words out MSB first behind a one-bit frame-sync pulse, and collects 16-bit words arriving on the input line behind a similar pulse. The internal datapath hands it transmit words through a valid/ready pair and receives collected words as a parallel value with a one-cycle strobe.

Every flop runs on the master clock. The serial clock is a registered, divided copy of it, and its rising and falling edges act as single-cycle enables inside the block. The serial-clock half period is the product of a master-clock divider factor and a serial-clock divider factor, so the full serial period (the two halves together) equals the master-clock factor times an even serial-clock factor. An asynchronous port enable takes the pads off the line at once. While it is low, the serial clock stops and all input activity is ignored. When it returns, a pending transmit word and the last received word are still there, but the clock divider and both framers start over.

Pad drivers sit outside the block. For that reason each tri-state output comes as a data bit with its own output-enable.

Top module: `sport_serdes`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, sclk is 0, sdofs is 0, sdo_oe is 0, rx_valid is 0, rx_data is 0 and tx_ready is 1.
- R2: With the port enabled, sclk is a square wave whose half period is (mdiv+1)*(sdiv+1) master-clock cycles, so its full period is twice that.
- R3: The output frame sync sdofs rises together with a rising sclk edge, stays high for exactly one sclk period, and is followed directly by the first data bit; sdo_oe is 0 while sdofs is 1.
- R4: A transmitted word appears on sdo as 16 bits, MSB (bit 15) first, one bit per sclk period, each bit changing on a rising sclk edge. sdo_oe is 1 for exactly those 16 periods and 0 at all other times.
- R5: tx_ready is 1 only when no word is pending. A word is accepted on a cycle with tx_valid and tx_ready both high, and tx_ready is 0 on the next cycle. A frame starts only when a word is pending and the port is enabled.
- R6: When sdifs is sampled high on a falling sclk edge while no input word is in progress, the next 16 falling edges sample sdi MSB first. On the 16th of them the word is placed on rx_data and rx_valid is high for exactly one master-clock cycle.
- R7: sdifs is ignored while an input word is in progress.
- R8: While en is low, pad_oe and sdo_oe are 0, sclk is held at 0 once the enable has passed its two-flop synchronizer, and sdi/sdifs produce no received word.
- R9: When en returns high, a word accepted before or during the disabled time is still pending and is transmitted, and rx_data keeps its last value.
- R10: If another word is pending when the last bit of a frame ends, the next frame sync is sent on the very next rising sclk edge, with no idle period between the frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Asynchronous port enable |
| mdiv | input | MDIV_W | Master-clock divider factor minus one |
| sdiv | input | SDIV_W | Serial-clock divider half-factor minus one |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | No word pending, offer is accepted |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| sclk | output | 1 | Serial clock |
| pad_oe | output | 1 | Output-enable for the sclk and sdofs pads |
| sdofs | output | 1 | Output frame sync |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output-enable for the sdo pad |
| sdifs | input | 1 | Input frame sync |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: WORD_W=16, MDIV_W=3 and SDIV_W=3. It drives the divider inputs first to mdiv=0, sdiv=0, a two-cycle serial period in which the rising and falling enables fall on consecutive master-clock cycles. It then uses mdiv=2, sdiv=1, a twelve-cycle period built from an uneven product. Both settings carry back-to-back transmit frames alongside full-duplex reception. Between the two settings the port is disabled, and the bench checks that pending and received words are retained.

// File: rtl/sport_serdes.sv
module sport_serdes #(
  parameter int WORD_W = 16,
  parameter int MDIV_W = 3,
  parameter int SDIV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MDIV_W-1:0] mdiv,
  input  logic [SDIV_W-1:0] sdiv,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sclk,
  output logic              pad_oe,
  output logic              sdofs,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdifs,
  input  logic              sdi
);

  localparam int CNT_W = MDIV_W + SDIV_W + 2;
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

  typedef enum logic [1:0] {T_IDLE, T_FS, T_DATA} tx_st_t;

  logic [1:0] en_q;
  logic       en_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= {en_q[0], en};
  assign en_s = en_q[1];

  logic [MDIV_W:0] mf;
  logic [SDIV_W:0] sf;
  logic [CNT_W-1:0] prod, cnt;
  logic sclk_r, tick, rise, fall;

  assign mf   = {1'b0, mdiv} + 1'b1;
  assign sf   = {1'b0, sdiv} + 1'b1;
  assign prod = mf * sf;
  assign tick = en_s && ((cnt + 1'b1) >= prod);
  assign rise = tick && !sclk_r;
  assign fall = tick && sclk_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sclk_r <= 1'b0;
    end else if (!en_s) begin
      cnt <= '0; sclk_r <= 1'b0;
    end else if (tick) begin
      cnt <= '0; sclk_r <= ~sclk_r;
    end else begin
      cnt <= cnt + 1'b1;
    end

  logic              pend;
  logic [WORD_W-1:0] hold, sh;
  logic [BIT_W-1:0]  tb;
  tx_st_t            tst;
  logic              fs_r, oe_r, load, accept;

  assign accept = tx_valid && !pend;
  assign load   = rise && pend && (tst == T_IDLE || (tst == T_DATA && tb == LAST));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0; hold <= '0;
    end else if (load) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend <= 1'b1; hold <= tx_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tst <= T_IDLE; fs_r <= 1'b0; oe_r <= 1'b0; sh <= '0; tb <= '0;
    end else if (!en_s) begin
      tst <= T_IDLE; fs_r <= 1'b0; oe_r <= 1'b0; tb <= '0;
    end else if (rise) begin
      if (load) begin
        tst <= T_FS; fs_r <= 1'b1; oe_r <= 1'b0; sh <= hold;
      end else begin
        case (tst)
          T_FS: begin
            tst <= T_DATA; fs_r <= 1'b0; oe_r <= 1'b1; tb <= '0;
          end
          T_DATA: begin
            if (tb == LAST) begin
              tst <= T_IDLE; oe_r <= 1'b0;
            end else begin
              sh <= sh << 1; tb <= tb + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

  assign tx_ready = !pend;
  assign sclk     = sclk_r;
  assign pad_oe   = en;
  assign sdofs    = fs_r;
  assign sdo      = sh[WORD_W-1];
  assign sdo_oe   = oe_r && en;

  logic              busy;
  logic [WORD_W-1:0] rsh;
  logic [BIT_W-1:0]  rb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; rsh <= '0; rb <= '0; rx_data <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!en_s) begin
        busy <= 1'b0; rb <= '0;
      end else if (fall) begin
        if (!busy) begin
          busy <= sdifs; rb <= '0;
        end else begin
          rsh <= {rsh[WORD_W-2:0], sdi};
          rb  <= rb + 1'b1;
          if (rb == LAST) begin
            busy <= 1'b0;
            rx_data <= {rsh[WORD_W-2:0], sdi};
            rx_valid <= 1'b1;
          end
        end
      end
    end

endmodule

module sport_serdes_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic en_s,
  input logic sclk,
  input logic sdofs,
  input logic sdo_oe,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready
);

  assert_fs_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdofs) |-> $rose(sclk));

  assert_fs_then_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdofs) && en_s && en) |-> sdo_oe);

  assert_oe_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe) && $stable(en)) |-> $rose(sclk));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdofs && sdo_oe));

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_clock_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !sclk);

endmodule

bind sport_serdes sport_serdes_chk chk (
  .clk(clk), .rst_n(rst_n), .en(en), .en_s(en_s), .sclk(sclk), .sdofs(sdofs),
  .sdo_oe(sdo_oe), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/sport_serdes_test.sv
module sport_serdes_test;

  localparam int W  = 16;
  localparam int MW = 3;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, tx_valid, sdifs, sdi;
  logic [MW-1:0] mdiv;
  logic [SW-1:0] sdiv;
  logic [W-1:0]  tx_data;
  logic tx_ready, rx_valid, sclk, pad_oe, sdofs, sdo, sdo_oe;
  logic [W-1:0] rx_data;

  sport_serdes #(.WORD_W(W), .MDIV_W(MW), .SDIV_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mdiv(mdiv), .sdiv(sdiv),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .pad_oe(pad_oe),
    .sdofs(sdofs), .sdo(sdo), .sdo_oe(sdo_oe), .sdifs(sdifs), .sdi(sdi)
  );

  int checks = 0;
  int fails  = 0;
  int hexp   = 1;
  int b2b    = 0;
  logic [W-1:0] txq[$];
  logic [W-1:0] rxq[$];
  logic [W-1:0] last_rx = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wait_rise();
    logic p;
    do begin
      p = sclk;
      @(negedge clk);
    end while (!(sclk && !p));
  endtask

  task automatic send_tx(input logic [W-1:0] w);
    while (!tx_ready) @(negedge clk);
    tx_data = w; tx_valid = 1'b1;
    txq.push_back(w);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R5 ready low after accept", tx_ready, 0);
  endtask

  task automatic send_rx(input logic [W-1:0] w, input bit fs_noise);
    rxq.push_back(w);
    wait_rise();
    sdifs = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      wait_rise();
      sdifs = fs_noise;
      sdi = w[i];
    end
    wait_rise();
    sdifs = 1'b0;
    last_rx = w;
  endtask

  task automatic drain();
    int n = 0;
    while ((txq.size() != 0 || rxq.size() != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4 * hexp + 4) @(negedge clk);
  endtask

  // transmit monitor: frames, bit order, serial period, back-to-back
  logic tprev = 1'b0;
  bit inf = 0, ended = 0, have_last = 0;
  int nb = 0, since = 0;
  logic [W-1:0] col = '0;
  always @(negedge clk) begin
    if (!rst_n || !en) begin
      inf = 0; ended = 0; have_last = 0; since = 0; tprev = 1'b0;
    end else begin
      since++;
      if (sclk && !tprev) begin
        bit was_end;
        if (have_last) chk(since == 2 * hexp, "R2 serial period", since, 2 * hexp);
        have_last = 1; since = 0;
        was_end = ended; ended = 0;
        if (inf) begin
          chk(sdo_oe && !sdofs, "R4 data period drive", {sdo_oe, sdofs}, 2'b10);
          col = {col[W-2:0], sdo};
          nb++;
          if (nb == W) begin
            inf = 0; ended = 1;
            if (txq.size() == 0) chk(0, "R4 unexpected frame", col, 0);
            else begin
              logic [W-1:0] e;
              e = txq.pop_front();
              chk(col == e, "R4 transmitted word", col, e);
            end
          end
        end else if (sdofs) begin
          chk(!sdo_oe, "R3 sync period sdo_oe", sdo_oe, 0);
          inf = 1; nb = 0;
          if (was_end) b2b++;
        end else begin
          chk(!sdo_oe, "R5 idle sdo_oe", sdo_oe, 0);
        end
      end
      tprev = sclk;
    end
  end

  // receive monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) chk(0, "R8 unexpected received word", rx_data, 0);
      else begin
        logic [W-1:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "R6 received word", rx_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-level run timeout actual=%0d expected=0", checks);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; tx_valid = 1'b0; tx_data = '0;
    sdifs = 1'b0; sdi = 1'b0; mdiv = '0; sdiv = '0; hexp = 1;
    repeat (5) @(negedge clk);
    chk(sclk == 0,     "R1 reset sclk", sclk, 0);
    chk(sdofs == 0,    "R1 reset sdofs", sdofs, 0);
    chk(sdo_oe == 0,   "R1 reset sdo_oe", sdo_oe, 0);
    chk(rx_valid == 0, "R1 reset rx_valid", rx_valid, 0);
    chk(rx_data == 0,  "R1 reset rx_data", rx_data, 0);
    chk(tx_ready == 1, "R1 reset tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 0 && tx_ready == 1, "R1 first cycle after reset", {sclk, tx_ready}, 2'b01);

    // fastest setting, full duplex, back-to-back frames, sync noise during input
    fork
      begin
        send_tx(16'hA5C3);
        send_tx(16'h8001);
        send_tx(16'h7FFE);
      end
      begin
        send_rx(16'hC3D2, 1'b0);
        send_rx(16'h5AA5, 1'b1);
      end
    join
    drain();
    chk(txq.size() == 0, "R4 all words sent", txq.size(), 0);
    chk(rxq.size() == 0, "R7 sync noise ignored, words received", rxq.size(), 0);
    chk(b2b == 2, "R10 back-to-back frames", b2b, 2);

    // disable: pads released, clock stopped, inputs ignored, word held
    en = 1'b0;
    @(negedge clk);
    chk(pad_oe == 0, "R8 pad_oe released", pad_oe, 0);
    chk(sdo_oe == 0, "R8 sdo_oe released", sdo_oe, 0);
    send_tx(16'h3C96);
    begin
      bit hi = 0;
      sdifs = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        sdi = i[0];
        if (i > 3 && sclk) hi = 1;
      end
      chk(!hi, "R8 sclk held low", hi, 0);
      sdifs = 1'b0;
    end
    chk(tx_ready == 0, "R5 word pending, no frame while disabled", tx_ready, 0);
    chk(txq.size() == 1, "R5 no frame while disabled", txq.size(), 1);
    chk(rx_data == last_rx, "R9 rx_data kept while disabled", rx_data, last_rx);
    mdiv = 3'd2; sdiv = 3'd1; hexp = 6;
    @(negedge clk);
    en = 1'b1;
    drain();
    chk(txq.size() == 0, "R9 pending word sent after enable", txq.size(), 0);
    chk(rx_data == last_rx, "R9 rx_data kept after enable", rx_data, last_rx);

    // slower uneven divisor
    b2b = 0;
    fork
      begin
        send_tx(16'h0F0F);
        send_tx(16'hFFFF);
      end
      begin
        send_rx(16'h0000, 1'b0);
        send_rx(16'hFFFF, 1'b0);
      end
    join
    drain();
    chk(txq.size() == 0, "R4 words sent at slow rate", txq.size(), 0);
    chk(rxq.size() == 0, "R6 words received at slow rate", rxq.size(), 0);
    chk(b2b == 1, "R10 back-to-back at slow rate", b2b, 1);

    finish_run();
  end

endmodule